// File: doc/BRIEF.md
# Timer Period Converter

This block turns a requested time interval, given in nanoseconds, into the setting of a two-stage hardware timer. The timer has a fixed base tick, for example 50 ns for a conversion clock or 100 ns for a scan clock. A 4-bit prescale multiplies that tick by (prescale + 1), and a 16-bit divider counts the resulting base. The block also reports the interval that the chosen setting actually produces, so that the requester can see the effect of rounding.

The search is sequential. The prescale starts at 0. For each prescale the block forms the base, adjusts the numerator for the selected rounding mode, and divides with a serial restoring divider that resolves one quotient bit per clock. The first prescale whose quotient fits in 16 bits ends the search. If none of the sixteen fits, the block saturates to the largest setting. The scale it reports in that case is a power of two, not the linear (prescale + 1) factor. A one-cycle `done` pulse marks a new result. The result stays on the outputs until the next one.

Top module: `tmr_period_cvt`

## Requirements
- R1: After reset, `timer_word` and `achieved_ns` are zero and `done` is low.
- R2: `timer_word` carries the prescale in bits 19:16 and the divider in bits 15:0.
- R3: With `round_mode` 0 or 3 (nearest), the divider is (period + base/2) / base, where base = tick × (prescale + 1) and the division is integer division.
- R4: With `round_mode` 1 (down), the divider is period / base.
- R5: With `round_mode` 2 (up), the divider is the ceiling (period + base − 1) / base.
- R6: The prescale reported is the smallest value in 0..15 whose divider is below 65536.
- R7: `achieved_ns` equals divider × base for the chosen prescale.
- R8: When no prescale gives a divider below 65536, the result is prescale 15, divider 65535, and `achieved_ns` = 65535 × tick × 32768.
- R9: `done` is high for exactly one cycle. It rises 35 × k clock edges after the edge that samples `start`, where k is the number of prescale values tried (16 when saturated).
- R10: A `start` that arrives while a conversion is running is ignored. It neither changes that conversion's result nor produces an extra `done`.
- R11: `timer_word` and `achieved_ns` keep their value between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion; sampled only while idle |
| period_ns | input | 32 | Requested interval in nanoseconds |
| tick_ns | input | 8 | Base tick of the timer in nanoseconds (nonzero) |
| round_mode | input | 2 | 0/3 nearest, 1 down, 2 up |
| timer_word | output | 20 | Packed prescale (19:16) and divider (15:0) |
| achieved_ns | output | 39 | Interval produced by the reported setting |
| done | output | 1 | One-cycle pulse when a new result is on the outputs |

## Verification
Each prescale step costs one setup cycle, 33 divider cycles and one decision cycle. A result is therefore due exactly 35 × k edges after `start` is sampled, where k is one more than the expected prescale, or 16 for a saturated request. The driver records the running cycle count when it raises `start`. It pushes the due cycle with the expected fields, which it computes from integer arithmetic of its own. The monitor samples on the falling edge and checks the arrival cycle as well as the values. It also confirms that `done` is low on the following cycle. A few cycles later the bench checks that the outputs have held.

// File: rtl/tmr_cvt_pkg.sv
package tmr_cvt_pkg;

   // rounding selection as seen on the round_mode port
   typedef enum logic [1:0] {
      RND_NEAREST     = 2'd0,
      RND_DOWN        = 2'd1,
      RND_UP          = 2'd2,
      RND_NEAREST_ALT = 2'd3
   } rnd_mode_e;

   // sequencer states of the converter
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_WAIT  = 2'd2
   } cvt_state_e;

endpackage

// File: rtl/tmr_step_prep.sv
// Forms the base and the rounding-adjusted numerator for one prescale step.
module tmr_step_prep #(
   parameter int PER_W   = 32,
   parameter int TICK_W  = 8,
   parameter int PRE_W   = 4,
   parameter bit UP_CEIL = 1'b1
) (
   input  logic [PER_W-1:0]        period,
   input  logic [TICK_W-1:0]       tick,
   input  logic [PRE_W-1:0]        pre,
   input  logic [1:0]              mode,
   output logic [TICK_W+PRE_W-1:0] base,
   output logic [PER_W:0]          num
);
   import tmr_cvt_pkg::*;

   localparam int DEN_W = TICK_W + PRE_W;
   localparam int NUM_W = PER_W + 1;

   logic [PRE_W:0] pre_plus;
   logic [DEN_W-1:0] half_base;
   logic [DEN_W-1:0] up_adj;
   logic [DEN_W-1:0] adj;

   assign pre_plus  = {1'b0, pre} + 1'b1;
   // tick * (pre + 1) always fits DEN_W bits
   assign base      = DEN_W'(tick) * DEN_W'(pre_plus);
   assign half_base = base >> 1;

   generate
      if (UP_CEIL) begin : g_up_ceil
         assign up_adj = (base == '0) ? '0 : base - 1'b1;
      end else begin : g_up_floor
         assign up_adj = '0;
      end
   endgenerate

   always_comb begin
      case (rnd_mode_e'(mode))
         RND_DOWN: adj = '0;
         RND_UP:   adj = up_adj;
         default:  adj = half_base;
      endcase
   end

   assign num = {1'b0, period} + NUM_W'(adj);

endmodule

// File: rtl/tmr_serial_div.sv
// Restoring divider, one quotient bit per clock.
module tmr_serial_div #(
   parameter int NUM_W = 33,
   parameter int DEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quo,
   output logic             vld
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [NUM_W-1:0] quo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             vld_q;

   logic [DEN_W:0]   shifted;
   logic             ge;
   logic [DEN_W-1:0] rem_next;

   assign shifted  = {rem_q, quo_q[NUM_W-1]};
   assign ge       = shifted >= {1'b0, den_q};
   assign rem_next = ge ? DEN_W'(shifted - {1'b0, den_q}) : shifted[DEN_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         den_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (start && !busy_q) begin
            rem_q  <= '0;
            den_q  <= den;
            quo_q  <= num;
            cnt_q  <= CNT_W'(NUM_W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            rem_q <= rem_next;
            quo_q <= {quo_q[NUM_W-2:0], ge};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               vld_q  <= 1'b1;
            end
         end
      end
   end

   assign quo = quo_q;
   assign vld = vld_q;

   AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && den_q != '0) |-> (rem_q < den_q)) else $error("remainder not below divisor"); // R4
   AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q) else $error("divider valid longer than one cycle"); // R9
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q) else $error("divider restarted while busy"); // R10

endmodule

// File: rtl/tmr_period_cvt.sv
// Period to prescale/divider converter: sequential search over the prescale.
module tmr_period_cvt #(
   parameter int PER_W   = 32,
   parameter int TICK_W  = 8,
   parameter int PRE_W   = 4,
   parameter int DIV_W   = 16,
   parameter bit UP_CEIL = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start,
   input  logic [PER_W-1:0]                    period_ns,
   input  logic [TICK_W-1:0]                   tick_ns,
   input  logic [1:0]                          round_mode,
   output logic [PRE_W+DIV_W-1:0]              timer_word,
   output logic [DIV_W+TICK_W+(2**PRE_W)-2:0]  achieved_ns,
   output logic                                done
);
   import tmr_cvt_pkg::*;

   localparam int NUM_W     = PER_W + 1;
   localparam int DEN_W     = TICK_W + PRE_W;
   localparam int SAT_SHIFT = (2**PRE_W) - 1;
   localparam int ACH_W     = DIV_W + TICK_W + SAT_SHIFT;
   localparam int WORD_W    = PRE_W + DIV_W;

   initial begin
      assert (PER_W >= DIV_W) else $error("period narrower than divider");
      assert (TICK_W >= 1)    else $error("tick width must be positive");
      assert (PRE_W >= 1 && PRE_W <= 5) else $error("prescale width out of range");
      assert (DIV_W >= 2)     else $error("divider too narrow");
   end

   cvt_state_e        state_q;
   logic [PER_W-1:0]  period_q;
   logic [TICK_W-1:0] tick_q;
   logic [1:0]        mode_q;
   logic [PRE_W-1:0]  pre_q;
   logic [WORD_W-1:0] word_q;
   logic [ACH_W-1:0]  ach_q;
   logic              done_q;

   logic [DEN_W-1:0]  base;
   logic [NUM_W-1:0]  num;
   logic [NUM_W-1:0]  quo;
   logic              quo_vld;
   logic              div_start;
   logic              fits;
   logic              last_pre;
   logic [ACH_W-1:0]  ach_fit;
   logic [ACH_W-1:0]  ach_sat;

   tmr_step_prep #(
      .PER_W  (PER_W),
      .TICK_W (TICK_W),
      .PRE_W  (PRE_W),
      .UP_CEIL(UP_CEIL)
   ) u_prep (
      .period(period_q),
      .tick  (tick_q),
      .pre   (pre_q),
      .mode  (mode_q),
      .base  (base),
      .num   (num)
   );

   assign div_start = (state_q == ST_SETUP);

   tmr_serial_div #(
      .NUM_W(NUM_W),
      .DEN_W(DEN_W)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .start(div_start),
      .num  (num),
      .den  (base),
      .quo  (quo),
      .vld  (quo_vld)
   );

   assign fits     = (quo[NUM_W-1:DIV_W] == '0);
   assign last_pre = (pre_q == {PRE_W{1'b1}});
   assign ach_fit  = ACH_W'(quo[DIV_W-1:0]) * ACH_W'(base);
   assign ach_sat  = (ACH_W'({DIV_W{1'b1}}) * ACH_W'(tick_q)) << SAT_SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         period_q <= '0;
         tick_q   <= '0;
         mode_q   <= '0;
         pre_q    <= '0;
         word_q   <= '0;
         ach_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  period_q <= period_ns;
                  tick_q   <= tick_ns;
                  mode_q   <= round_mode;
                  pre_q    <= '0;
                  state_q  <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (quo_vld) begin
                  if (fits) begin
                     word_q  <= {pre_q, quo[DIV_W-1:0]};
                     ach_q   <= ach_fit;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (last_pre) begin
                     word_q  <= {{PRE_W{1'b1}}, {DIV_W{1'b1}}};
                     ach_q   <= ach_sat;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     pre_q   <= pre_q + 1'b1;
                     state_q <= ST_SETUP;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign timer_word  = word_q;
   assign achieved_ns = ach_q;
   assign done        = done_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q) else $error("done held too long"); // R9
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && start) |=> ($stable(period_q) && $stable(tick_q) && $stable(mode_q)))
      else $error("request captured while busy"); // R10
   AST_PRE_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETUP && $past(state_q) == ST_WAIT) |-> (pre_q == $past(pre_q) + 1'b1))
      else $error("prescale did not advance by one"); // R6
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(timer_word) || !$stable(achieved_ns)) |-> done_q)
      else $error("outputs changed without done"); // R11

endmodule

// File: tb/test_tmr_period_cvt.sv
module test_tmr_period_cvt;

   localparam int CLK_PERIOD = 10;
   localparam int PER_W      = 32;
   localparam int TICK_W     = 8;
   localparam int PRE_W      = 4;
   localparam int DIV_W      = 16;
   localparam int ACH_W      = DIV_W + TICK_W + (2**PRE_W) - 1;
   localparam int LAT_STEP   = PER_W + 3;

   logic                    clk;
   logic                    rst_n;
   logic                    start;
   logic [PER_W-1:0]        period_ns;
   logic [TICK_W-1:0]       tick_ns;
   logic [1:0]              round_mode;
   logic [PRE_W+DIV_W-1:0]  timer_word;
   logic [ACH_W-1:0]        achieved_ns;
   logic                    done;

   tmr_period_cvt #(
      .PER_W (PER_W),
      .TICK_W(TICK_W),
      .PRE_W (PRE_W),
      .DIV_W (DIV_W)
   ) i_tmr_period_cvt (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .period_ns  (period_ns),
      .tick_ns    (tick_ns),
      .round_mode (round_mode),
      .timer_word (timer_word),
      .achieved_ns(achieved_ns),
      .done       (done)
   );

   typedef struct {
      longint unsigned pre;
      longint unsigned dv;
      longint unsigned ach;
      longint          due;
      string           tag;
   } exp_t;

   exp_t   sb_q[$];
   int     n_chk = 0;
   int     n_err = 0;
   longint cyc   = 0;
   bit     chk_low = 0;
   longint unsigned last_word = 0;
   longint unsigned last_ach  = 0;

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // independent reference: linear prescale search, power-of-two saturation
   function automatic exp_t model(input longint unsigned p, input longint unsigned t,
                                  input int m, input string tag, output int steps);
      exp_t e;
      e.tag = tag;
      e.due = 0;
      for (int pr = 0; pr < 16; pr++) begin
         longint unsigned b;
         longint unsigned n;
         longint unsigned d;
         b = t * longint'(pr + 1);
         if (m == 1)      n = p;
         else if (m == 2) n = p + b - 1;
         else             n = p + b / 2;
         d = n / b;
         if (d < 65536) begin
            e.pre = longint'(pr);
            e.dv  = d;
            e.ach = d * b;
            steps = pr + 1;
            return e;
         end
      end
      e.pre = 15;
      e.dv  = 65535;
      e.ach = 65535 * t * 32768;
      steps = 16;
      return e;
   endfunction

   // driver: one conversion, optional start pulse while busy
   task automatic run(input longint unsigned p, input longint unsigned t, input int m,
                      input string tag, input bit poke);
      exp_t e;
      int   steps;
      @(negedge clk);
      start      = 1'b1;
      period_ns  = PER_W'(p);
      tick_ns    = TICK_W'(t);
      round_mode = 2'(m);
      e = model(p, t, m, tag, steps);
      e.due = cyc + 1 + longint'(steps * LAT_STEP);
      sb_q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         start      = 1'b1;
         period_ns  = 32'd777;
         tick_ns    = 8'd3;
         round_mode = 2'd2;
         @(negedge clk);
         start = 1'b0;
      end
      while (sb_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(longint'(timer_word) == longint'(last_word), "R11", "word held",
          longint'(timer_word), longint'(last_word));
      chk(longint'(achieved_ns) == longint'(last_ach), "R11", "period held",
          longint'(achieved_ns), longint'(last_ach));
   endtask

   // monitor: pops the scoreboard on every done
   always @(negedge clk) begin
      if (rst_n) begin
         if (chk_low) begin
            chk(!done, "R9", "done width", longint'(done), 0);
            chk_low = 0;
         end else if (done) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(longint'(timer_word[19:16]) == longint'(e.pre), "R6", "prescale",
                   longint'(timer_word[19:16]), longint'(e.pre));
               chk(longint'(timer_word[15:0]) == longint'(e.dv), e.tag, "divider",
                   longint'(timer_word[15:0]), longint'(e.dv));
               chk(longint'(timer_word) == longint'((e.pre << 16) | e.dv), "R2", "packing",
                   longint'(timer_word), longint'((e.pre << 16) | e.dv));
               chk(longint'(achieved_ns) == longint'(e.ach), "R7", "achieved",
                   longint'(achieved_ns), longint'(e.ach));
               chk(cyc == e.due, "R9", "latency", cyc, e.due);
            end
            last_word = longint'(timer_word);
            last_ach  = longint'(achieved_ns);
            chk_low = 1;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      start      = 1'b0;
      period_ns  = '0;
      tick_ns    = 8'd50;
      round_mode = 2'd0;
      repeat (3) @(negedge clk);
      chk(timer_word == '0, "R1", "reset word", longint'(timer_word), 0);
      chk(achieved_ns == '0, "R1", "reset period", longint'(achieved_ns), 0);
      chk(!done, "R1", "reset done", longint'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(timer_word == '0 && !done, "R1", "idle after reset", longint'(timer_word), 0);

      run(1000,     50, 0, "R3", 0);
      run(1024,     50, 0, "R3", 0);
      run(1024,     50, 1, "R4", 0);
      run(1024,     50, 2, "R5", 0);
      run(1025,     50, 3, "R3", 0);
      run(10,       7,  0, "R3", 0);
      run(11,       7,  0, "R3", 0);
      run(3276750,  50, 1, "R4", 0);
      run(3276800,  50, 1, "R6", 0);
      run(3276775,  50, 0, "R6", 0);
      run(3276751,  50, 2, "R5", 0);
      run(50000000, 100, 1, "R6", 0);
      run(0,        50, 2, "R5", 0);
      run(64'hFFFF_FFFF, 50, 0, "R8", 0);
      run(64'hFFFF_FFFF, 255, 1, "R8", 0);
      run(123457,   100, 0, "R10", 1);
      run(5000000,  50, 2, "R10", 1);

      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule